// File: doc/BRIEF.md
# Cycle Timer Interrupt with Outer PRG Banking

This block is a board-level add-on that sits beside a serially loaded bank register set. It keeps a free-running CPU-cycle counter whose expiry point is tuned by a four-bit switch setting. When the counter expires, the block raises a level interrupt that stays up until software acknowledges it. The acknowledge path is the same control bit that holds the counter stopped.

The block also takes over program-memory banking. One stored control bit picks between two windows. In the first window, a single 32 KB page is taken from the low 128 KB. In the second window, the usual four 16 KB banking modes apply, but every bank number is forced into the high 128 KB.

Software writes the control value through the first character-bank register of the serial set. That register's commit pulse and its upper four data bits are the block's control inputs.

Top module: `cyc_irq_outer_bank`

## Requirements
- R1: The counter advances by one on each clock where `cpu_cycle` is high and the stored control bit 4 is clear. It holds its value while control bit 4 is set or `cpu_cycle` is low.
- R2: Let the incremented count be ORed with `dip_sel` placed at bits CNT_W-2 down to CNT_W-5. When the top five bits of that result are all ones, the counter loads zero and `irq` goes high on the same edge. For CNT_W=10 this takes 544 enabled cycles with switch value 0xE, 512 with 0xF and 992 with 0x0.
- R3: A commit with data bit 4 set clears the counter and drives `irq` low at the next edge.
- R4: Once high, `irq` stays high until a commit with data bit 4 set, even while the counter keeps running.
- R5: While stored control bit 3 is clear, the low 16 KB bank is 2×(bits 2:1) and the high bank is that value plus one. Both lie in banks 0 to 7, and `prg_mode` and `prg_bank_sel` have no effect.
- R6: While control bit 3 is set and `prg_mode` is 0 or 1, the low bank is 8 | (sel & 6) and the high bank is that value | 1.
- R7: While control bit 3 is set and `prg_mode` is 2, the low bank is fixed at 8 and the high bank is 8 | (sel & 7).
- R8: While control bit 3 is set and `prg_mode` is 3, the low bank is 8 | (sel & 7) and the high bank is fixed at 15.
- R9: `dip_sel` is not latched. A change takes part in the very next comparison.
- R10: Reset clears the counter, `irq` and the stored control value. The outputs then show low bank 0 and high bank 1, and the timer is running.
- R11: A commit with data bit 4 clear stores the new control value and leaves the counter and `irq` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cycle | input | 1 | One pulse per CPU cycle |
| dip_sel | input | 4 | Switch setting that tunes the expiry point |
| chrsel_we | input | 1 | Commit pulse of the control register |
| chrsel_wdata | input | 4 | Control data bits 4:1 |
| prg_mode | input | 2 | 16 KB banking mode from the serial set |
| prg_bank_sel | input | 4 | PRG bank value from the serial set |
| irq | output | 1 | Level interrupt request, active high |
| prg_bank_lo | output | 4 | 16 KB bank number for the lower half of the PRG window |
| prg_bank_hi | output | 4 | 16 KB bank number for the upper half of the PRG window |

## Verification
A commit changes the stored control value on the edge that samples it. The bank outputs are combinational from that value and from the live mode and select inputs, so they are due one edge after a commit. The interrupt is due on the same edge that counts the final enabled cycle, and an acknowledge takes effect one edge after its commit. The bench drives every input on the falling edge and counts the enabled rising edges exactly (543 then 1 for the 0xE case). It samples on the following falling edge, so each check lands in the cycle where the result is first due, and also in the cycle just before.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
    localparam int BANK_W = 4;
    localparam int CTRL_W = 4;

    typedef enum logic [1:0] {
        PM_WIDE_A  = 2'd0,
        PM_WIDE_B  = 2'd1,
        PM_FIX_LOW = 2'd2,
        PM_FIX_TOP = 2'd3
    } prg_mode_e;
endpackage

// File: rtl/cit_ctrl_reg.sv
module cit_ctrl_reg
    import cyc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W:1]   wdata,
    output logic [CTRL_W:1]   val_q
);
    typedef struct packed {
        logic [CTRL_W:1] val;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.val = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_q = st_q.val;
endmodule

// File: rtl/cit_timer.sv
module cit_timer #(
    parameter int CNT_W = 30,
    parameter int DIP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_cycle,
    input  logic             hold,
    input  logic             ack,
    input  logic [DIP_W-1:0] dip_sel,
    output logic [CNT_W-1:0] count_q,
    output logic             irq
);
    localparam int TOP_W = DIP_W + 1;
    localparam int SHIFT = CNT_W - TOP_W;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
    } tmr_s;

    tmr_s             st_d, st_q;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] merged;
    logic             expire;

    always_comb begin
        inc    = st_q.count + CNT_W'(1);
        merged = inc | (CNT_W'(dip_sel) << SHIFT);
        expire = &merged[CNT_W-1 -: TOP_W];
        st_d   = st_q;
        if (ack) begin
            st_d.count = '0;
            st_d.irq   = 1'b0;
        end else if (cpu_cycle && !hold) begin
            if (expire) begin
                st_d.count = '0;
                st_d.irq   = 1'b1;
            end else begin
                st_d.count = inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.count;
    assign irq     = st_q.irq;
endmodule

// File: rtl/cit_prg_map.sv
module cit_prg_map
    import cyc_irq_pkg::*;
(
    input  logic [3:1]        ctrl,
    input  logic [1:0]        prg_mode,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [BANK_W-1:0] bank_lo,
    output logic [BANK_W-1:0] bank_hi
);
    localparam logic [BANK_W-1:0] UPPER = BANK_W'(1) << (BANK_W - 1);
    localparam logic [BANK_W-1:0] INNER = UPPER - BANK_W'(1);
    localparam logic [BANK_W-1:0] PAIR  = INNER & ~BANK_W'(1);

    logic [BANK_W-1:0] wide_base;

    always_comb begin
        wide_base = UPPER | (bank_sel & PAIR);
        if (!ctrl[3]) begin
            bank_lo = {1'b0, ctrl[2:1], 1'b0};
            bank_hi = {1'b0, ctrl[2:1], 1'b1};
        end else begin
            case (prg_mode_e'(prg_mode))
                PM_FIX_LOW: begin
                    bank_lo = UPPER;
                    bank_hi = UPPER | (bank_sel & INNER);
                end
                PM_FIX_TOP: begin
                    bank_lo = UPPER | (bank_sel & INNER);
                    bank_hi = UPPER | INNER;
                end
                default: begin
                    bank_lo = wide_base;
                    bank_hi = wide_base | BANK_W'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/cyc_irq_outer_bank.sv
module cyc_irq_outer_bank
    import cyc_irq_pkg::*;
#(
    parameter int CNT_W = 30,
    parameter int DIP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_cycle,
    input  logic [DIP_W-1:0]  dip_sel,
    input  logic              chrsel_we,
    input  logic [CTRL_W:1]   chrsel_wdata,
    input  logic [1:0]        prg_mode,
    input  logic [BANK_W-1:0] prg_bank_sel,
    output logic              irq,
    output logic [BANK_W-1:0] prg_bank_lo,
    output logic [BANK_W-1:0] prg_bank_hi
);
    logic [CTRL_W:1]  ctrl_q;
    logic [CNT_W-1:0] count_q;
    logic             ack;

    assign ack = chrsel_we && chrsel_wdata[4];

    cit_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (chrsel_we),
        .wdata (chrsel_wdata),
        .val_q (ctrl_q)
    );

    cit_timer #(
        .CNT_W (CNT_W),
        .DIP_W (DIP_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_cycle (cpu_cycle),
        .hold      (ctrl_q[4]),
        .ack       (ack),
        .dip_sel   (dip_sel),
        .count_q   (count_q),
        .irq       (irq)
    );

    cit_prg_map u_map (
        .ctrl     (ctrl_q[3:1]),
        .prg_mode (prg_mode),
        .bank_sel (prg_bank_sel),
        .bank_lo  (prg_bank_lo),
        .bank_hi  (prg_bank_hi)
    );
endmodule

// File: rtl/cyc_irq_outer_bank_chk.sv
module cyc_irq_outer_bank_chk #(
    parameter int CNT_W = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_cycle,
    input logic             chrsel_we,
    input logic [4:1]       chrsel_wdata,
    input logic [1:0]       prg_mode,
    input logic [4:1]       ctrl_q,
    input logic [CNT_W-1:0] count_q,
    input logic             irq,
    input logic [3:0]       prg_bank_lo,
    input logic [3:0]       prg_bank_hi
);
    p_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!chrsel_we && (ctrl_q[4] || !cpu_cycle)) |=> $stable(count_q));

    p_expire_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (count_q == '0));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chrsel_we && chrsel_wdata[4]) |=> (!irq && count_q == '0));

    p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(chrsel_we && chrsel_wdata[4])) |=> irq);

    p_outer_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[3] |-> (!prg_bank_lo[3] && !prg_bank_hi[3] && !prg_bank_lo[0]
                        && prg_bank_hi == prg_bank_lo + 4'd1));

    p_inner_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[3] |-> (prg_bank_lo[3] && prg_bank_hi[3]));

    p_fix_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3] && prg_mode == 2'd3) |-> (prg_bank_hi == 4'hF));
endmodule

bind cyc_irq_outer_bank cyc_irq_outer_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_cycle    (cpu_cycle),
    .chrsel_we    (chrsel_we),
    .chrsel_wdata (chrsel_wdata),
    .prg_mode     (prg_mode),
    .ctrl_q       (ctrl_q),
    .count_q      (count_q),
    .irq          (irq),
    .prg_bank_lo  (prg_bank_lo),
    .prg_bank_hi  (prg_bank_hi)
);

// File: tb/cyc_irq_outer_bank_bench.sv
`timescale 1ns/1ps
module cyc_irq_outer_bank_bench;
    localparam int CNT_W = 10;
    localparam int NV    = 11;
    // {ctrl[4:1], mode, sel, exp_lo, exp_hi}
    localparam logic [17:0] VEC [NV] = '{
        {4'h0, 2'd0, 4'd0,  4'd0,  4'd1 },  // R5
        {4'h1, 2'd0, 4'd0,  4'd2,  4'd3 },  // R5
        {4'h3, 2'd3, 4'd5,  4'd6,  4'd7 },  // R5 mode ignored
        {4'h2, 2'd2, 4'd7,  4'd4,  4'd5 },  // R5
        {4'h4, 2'd0, 4'd5,  4'd12, 4'd13},  // R6
        {4'h4, 2'd1, 4'd3,  4'd10, 4'd11},  // R6
        {4'h7, 2'd0, 4'd14, 4'd14, 4'd15},  // R6
        {4'h4, 2'd2, 4'd5,  4'd8,  4'd13},  // R7
        {4'hC, 2'd2, 4'd0,  4'd8,  4'd8 },  // R7
        {4'h4, 2'd3, 4'd5,  4'd13, 4'd15},  // R8
        {4'h5, 2'd3, 4'd15, 4'd15, 4'd15}   // R8
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cycle = 1'b0;
    logic [3:0] dip_sel = 4'hE;
    logic       chrsel_we = 1'b0;
    logic [4:1] chrsel_wdata = '0;
    logic [1:0] prg_mode = '0;
    logic [3:0] prg_bank_sel = '0;
    logic       irq;
    logic [3:0] prg_bank_lo, prg_bank_hi;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cyc_irq_outer_bank #(.CNT_W(CNT_W), .DIP_W(4)) u_cyc_irq_outer_bank (
        .clk(clk), .rst_n(rst_n), .cpu_cycle(cpu_cycle), .dip_sel(dip_sel),
        .chrsel_we(chrsel_we), .chrsel_wdata(chrsel_wdata), .prg_mode(prg_mode),
        .prg_bank_sel(prg_bank_sel), .irq(irq), .prg_bank_lo(prg_bank_lo),
        .prg_bank_hi(prg_bank_hi)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic commit(input logic [4:1] v);
        chrsel_wdata = v;
        chrsel_we    = 1'b1;
        @(negedge clk);
        chrsel_we    = 1'b0;
    endtask

    task automatic run(input int n);
        cpu_cycle = 1'b1;
        repeat (n) @(negedge clk);
        cpu_cycle = 1'b0;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 irq", irq, 0);
        check("R10 lo", prg_bank_lo, 0);
        check("R10 hi", prg_bank_hi, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // mapping vectors
        for (int i = 0; i < NV; i++) begin
            prg_mode     = VEC[i][13:12];
            prg_bank_sel = VEC[i][11:8];
            commit(VEC[i][17:14]);
            check($sformatf("R5-8 lo vec%0d", i), prg_bank_lo, VEC[i][7:4]);
            check($sformatf("R5-8 hi vec%0d", i), prg_bank_hi, VEC[i][3:0]);
        end

        // R10: timer runs from reset value: expiry after 544 enabled cycles
        commit(4'h8);
        commit(4'h0);
        run(543);
        check("R2 before expiry dip E", irq, 0);
        run(1);
        check("R2 expiry dip E", irq, 1);
        // R4: level held while counting and on non-ack commit
        run(700);
        check("R4 irq held while counting", irq, 1);
        commit(4'h4);
        check("R11 irq kept on commit bit4 clear", irq, 1);
        commit(4'hC);
        check("R3 ack clears irq", irq, 0);

        // R1: frozen while bit 4 set
        run(1000);
        check("R1 no count while held", irq, 0);
        commit(4'h0);
        repeat (600) @(negedge clk);
        check("R1 no count without cpu_cycle", irq, 0);
        run(543);
        check("R1 count from zero before expiry", irq, 0);
        run(1);
        check("R1 count expiry", irq, 1);

        // R11: bit4-clear commit does not reset counter
        commit(4'h8);
        commit(4'h0);
        run(300);
        commit(4'h4);
        run(243);
        check("R11 counter kept before expiry", irq, 0);
        run(1);
        check("R11 counter kept expiry", irq, 1);

        // R2: other switch values
        dip_sel = 4'hF;
        commit(4'h8);
        commit(4'h0);
        run(511);
        check("R2 before expiry dip F", irq, 0);
        run(1);
        check("R2 expiry dip F", irq, 1);
        dip_sel = 4'h0;
        commit(4'h8);
        commit(4'h0);
        run(991);
        check("R2 before expiry dip 0", irq, 0);
        run(1);
        check("R2 expiry dip 0", irq, 1);

        // R9: live switch change
        commit(4'h8);
        commit(4'h0);
        run(600);
        check("R9 no expiry at dip 0", irq, 0);
        dip_sel = 4'hF;
        @(negedge clk);
        check("R9 idle cycle no expiry", irq, 0);
        run(1);
        check("R9 expiry after switch change", irq, 1);

        done = 1'b1;
        finish_run();
    end
endmodule